// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block sits between dispatch and the architectural state of a speculative out-of-order core. It holds the results of instructions that have not retired yet. Each dispatched instruction takes the slot at the tail of a circular buffer. The slot index is returned to dispatch and serves as the rename tag for that instruction's result. Functional units finish in any order and write their value, plus an optional fault flag, back through a single result port that is addressed by tag.

Retirement happens only at the head, one entry per cycle, and only once that entry holds its result. A retiring register-writing entry drives the register-file write port. A retiring store drives the store port. A retiring branch has no side effect. Fault flags are kept in the entries and take effect only at the head. A faulting entry raises a precise exception and empties the buffer.

A branch mispredict pulls the tail back to the slot after the branch, which discards every younger entry. Dispatch also uses lookup ports to find operands. A lookup names an architectural register and gets back the youngest live producer of that register, its tag, and its value if that value has already been produced. The register-to-producer mapping is derived from the live entries on every lookup, so it returns to the correct state on its own after a flush.

Top module: `rob_top`

## Requirements
- R1: A dispatch that is accepted allocates the slot shown on `disp_tag`. `disp_tag` then advances by one, modulo DEPTH.
- R2: `full` is high exactly when DEPTH entries are live. A dispatch offered while `full` is high is dropped, and `disp_tag` does not move.
- R3: A result-port write marks the tagged entry ready and stores its value and its fault flag.
- R4: Only the head entry retires, and only once it is ready. A younger entry that is ready waits until every older entry has retired.
- R5: Kind encoding is 0 = register write, 1 = store, 2 = branch. A kind-0 entry retiring without a fault drives `rf_we` for one cycle, with `rf_addr` equal to the low REG_W bits of its destination and `rf_data` equal to its value.
- R6: A kind-1 entry retiring without a fault drives `st_en`, with `st_addr` equal to its destination and `st_data` equal to its value. A kind-2 entry retires with no write, no store and no exception.
- R7: For each lookup port, `lk_busy` is high when some live kind-0 entry targets the named register. In that case `lk_tag`, `lk_ready` and `lk_value` come from the youngest such entry.
- R8: `flush_valid` with `flush_tag` discards every entry younger than the tagged one and sets the next allocation slot to the one after it. A dispatch offered in the same cycle is dropped. Lookups afterwards no longer see the discarded producers.
- R9: A newly allocated entry is not ready, even if a result was written into that slot before it was discarded.
- R10: A faulting entry at the head raises `exc_raise` for one cycle, with `exc_tag` set to its slot. It performs no register write and no store, and the buffer is empty in the following cycle.
- R11: A fault recorded in an entry that a flush discards is never raised.
- R12: After reset the buffer is empty: nothing retires, `full` is low and `disp_tag` is 0. The live count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | Entry kind: 0 register, 1 store, 2 branch |
| disp_dest | input | DEST_W | Destination register number or store address |
| disp_tag | output | log2(DEPTH) | Slot the next accepted dispatch takes |
| full | output | 1 | All slots live; dispatch stalls |
| res_valid | input | 1 | Result write |
| res_tag | input | log2(DEPTH) | Slot being completed |
| res_value | input | DATA_W | Result or store data |
| res_exc | input | 1 | Fault flag for the completed instruction |
| flush_valid | input | 1 | Branch mispredict |
| flush_tag | input | log2(DEPTH) | Slot of the mispredicted branch |
| lk_reg | input | NUM_RD*REG_W | Register number for each lookup port |
| lk_busy | output | NUM_RD | A live producer exists |
| lk_tag | output | NUM_RD*log2(DEPTH) | Tag of the youngest producer |
| lk_ready | output | NUM_RD | Producer value present |
| lk_value | output | NUM_RD*DATA_W | Producer value |
| rf_we | output | 1 | Register write at retirement |
| rf_addr | output | REG_W | Register written |
| rf_data | output | DATA_W | Value written |
| st_en | output | 1 | Store at retirement |
| st_addr | output | DEST_W | Store address |
| st_data | output | DATA_W | Store data |
| exc_raise | output | 1 | Precise exception at the head |
| exc_tag | output | log2(DEPTH) | Slot of the faulting entry |

## Verification
The bench uses DEPTH = 4, DATA_W = 8, DEST_W = 8, REG_W = 5 and two lookup ports. With four slots, a few dispatches are enough to reach a full buffer, a stalled dispatch, and a tail index that wraps past zero. The wrap bit is exercised with both pointers in their second lap. Two lookup ports let one check read a busy register and an idle register in the same cycle. Two dispatches to the same register confirm that the youngest producer wins. With the small depth, a mispredict can discard the two youngest slots and then reuse one of them while it still holds an old result.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
    typedef enum logic [1:0] {
        KIND_REG    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } rob_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
`timescale 1ns/1ps
// Head/tail pointers carrying one extra lap bit.
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush_all,
    input  logic             flush_valid,
    input  logic [IDX_W-1:0] flush_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [PTR_W-1:0] count,
    output logic             empty,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [IDX_W-1:0] keep_dist;

    assign head_idx = st_q.head[IDX_W-1:0];
    assign tail_idx = st_q.tail[IDX_W-1:0];
    assign count    = st_q.tail - st_q.head;
    assign empty    = (count == '0);
    assign full     = (count == PTR_W'(DEPTH));

    always_comb begin
        st_d      = st_q;
        keep_dist = flush_idx - st_q.head[IDX_W-1:0];
        if (pop) begin
            st_d.head = st_q.head + PTR_W'(1);
        end
        if (flush_all) begin
            st_d.tail = st_q.head + PTR_W'(1);
        end else if (flush_valid) begin
            st_d.tail = st_q.head + PTR_W'(keep_dist) + PTR_W'(1);
        end else if (push) begin
            st_d.tail = st_q.tail + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PTR_W'(DEPTH)); // R12

    AST_FLUSH_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !flush_all) |=> (count <= $past(count))); // R8
endmodule

// File: rtl/rob_store.sv
`timescale 1ns/1ps
// Entry storage: kind, destination, value, ready and fault per slot.
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int DEST_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           alloc,
    input  logic [IDX_W-1:0]               alloc_idx,
    input  logic [1:0]                     alloc_kind,
    input  logic [DEST_W-1:0]              alloc_dest,
    input  logic                           wr_valid,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_value,
    input  logic                           wr_exc,
    output logic [DEPTH-1:0][1:0]          kind_o,
    output logic [DEPTH-1:0][DEST_W-1:0]   dest_o,
    output logic [DEPTH-1:0][DATA_W-1:0]   value_o,
    output logic [DEPTH-1:0]               ready_o,
    output logic [DEPTH-1:0]               exc_o
);
    typedef struct packed {
        logic [1:0]        kind;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] value;
        logic              ready;
        logic              exc;
    } entry_t;

    entry_t [DEPTH-1:0] ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (wr_valid) begin
            ent_d[wr_idx].value = wr_value;
            ent_d[wr_idx].ready = 1'b1;
            ent_d[wr_idx].exc   = wr_exc;
        end
        if (alloc) begin
            ent_d[alloc_idx].kind  = alloc_kind;
            ent_d[alloc_idx].dest  = alloc_dest;
            ent_d[alloc_idx].value = '0;
            ent_d[alloc_idx].ready = 1'b0;
            ent_d[alloc_idx].exc   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            ent_q <= ent_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign kind_o[g]  = ent_q[g].kind;
        assign dest_o[g]  = ent_q[g].dest;
        assign value_o[g] = ent_q[g].value;
        assign ready_o[g] = ent_q[g].ready;
        assign exc_o[g]   = ent_q[g].exc;

        AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (ready_o[g] && !(alloc && alloc_idx == IDX_W'(g))) |=> ready_o[g]); // R3
    end
endmodule

// File: rtl/rob_lookup.sv
`timescale 1ns/1ps
// One operand lookup: youngest live register producer, by age scan from head.
module rob_lookup #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic [IDX_W-1:0]             head_idx,
    input  logic [PTR_W-1:0]             count,
    input  logic [DEPTH-1:0][1:0]        kinds,
    input  logic [DEPTH-1:0][REG_W-1:0]  regs,
    input  logic [DEPTH-1:0][DATA_W-1:0] values,
    input  logic [DEPTH-1:0]             readies,
    input  logic [REG_W-1:0]             reg_num,
    output logic                         busy,
    output logic [IDX_W-1:0]             tag,
    output logic                         ready,
    output logic [DATA_W-1:0]            value
);
    import rob_pkg::*;

    logic [IDX_W-1:0] slot;

    always_comb begin
        busy  = 1'b0;
        tag   = '0;
        ready = 1'b0;
        value = '0;
        slot  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = head_idx + IDX_W'(i);
            if ((PTR_W'(i) < count) && (kinds[slot] == KIND_REG) &&
                (regs[slot] == reg_num)) begin
                busy  = 1'b1;
                tag   = slot;
                ready = readies[slot];
                value = values[slot];
            end
        end
    end
endmodule

// File: rtl/rob_top.sv
`timescale 1ns/1ps
module rob_top #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int DEST_W = 32,
    parameter int REG_W  = 5,
    parameter int NUM_RD = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [1:0]               disp_kind,
    input  logic [DEST_W-1:0]        disp_dest,
    output logic [IDX_W-1:0]         disp_tag,
    output logic                     full,
    input  logic                     res_valid,
    input  logic [IDX_W-1:0]         res_tag,
    input  logic [DATA_W-1:0]        res_value,
    input  logic                     res_exc,
    input  logic                     flush_valid,
    input  logic [IDX_W-1:0]         flush_tag,
    input  logic [NUM_RD*REG_W-1:0]  lk_reg,
    output logic [NUM_RD-1:0]        lk_busy,
    output logic [NUM_RD*IDX_W-1:0]  lk_tag,
    output logic [NUM_RD-1:0]        lk_ready,
    output logic [NUM_RD*DATA_W-1:0] lk_value,
    output logic                     rf_we,
    output logic [REG_W-1:0]         rf_addr,
    output logic [DATA_W-1:0]        rf_data,
    output logic                     st_en,
    output logic [DEST_W-1:0]        st_addr,
    output logic [DATA_W-1:0]        st_data,
    output logic                     exc_raise,
    output logic [IDX_W-1:0]         exc_tag
);
    import rob_pkg::*;

    logic [IDX_W-1:0]             head_idx;
    logic [IDX_W-1:0]             tail_idx;
    logic [PTR_W-1:0]             count;
    logic                         empty;
    logic                         push;
    logic                         pop;
    logic                         head_ok;
    logic                         head_clean;
    logic [DEPTH-1:0][1:0]        kinds;
    logic [DEPTH-1:0][DEST_W-1:0] dests;
    logic [DEPTH-1:0][REG_W-1:0]  reg_fields;
    logic [DEPTH-1:0][DATA_W-1:0] values;
    logic [DEPTH-1:0]             readies;
    logic [DEPTH-1:0]             excs;

    // Retirement decision at the head
    always_comb begin
        head_ok    = !empty && readies[head_idx];
        head_clean = head_ok && !excs[head_idx];
        exc_raise  = head_ok && excs[head_idx];
        exc_tag    = head_idx;
        rf_we      = head_clean && (kinds[head_idx] == KIND_REG);
        rf_addr    = reg_fields[head_idx];
        rf_data    = values[head_idx];
        st_en      = head_clean && (kinds[head_idx] == KIND_STORE);
        st_addr    = dests[head_idx];
        st_data    = values[head_idx];
        pop        = head_ok;
        push       = disp_valid && !full && !flush_valid && !exc_raise;
    end

    assign disp_tag = tail_idx;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .pop         (pop),
        .flush_all   (exc_raise),
        .flush_valid (flush_valid),
        .flush_idx   (flush_tag),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .count       (count),
        .empty       (empty),
        .full        (full)
    );

    rob_store #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (push),
        .alloc_idx  (tail_idx),
        .alloc_kind (disp_kind),
        .alloc_dest (disp_dest),
        .wr_valid   (res_valid),
        .wr_idx     (res_tag),
        .wr_value   (res_value),
        .wr_exc     (res_exc),
        .kind_o     (kinds),
        .dest_o     (dests),
        .value_o    (values),
        .ready_o    (readies),
        .exc_o      (excs)
    );

    for (genvar e = 0; e < DEPTH; e++) begin : g_regf
        assign reg_fields[e] = dests[e][REG_W-1:0];
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_lk
        rob_lookup #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REG_W(REG_W)) u_lk (
            .head_idx (head_idx),
            .count    (count),
            .kinds    (kinds),
            .regs     (reg_fields),
            .values   (values),
            .readies  (readies),
            .reg_num  (lk_reg[p*REG_W +: REG_W]),
            .busy     (lk_busy[p]),
            .tag      (lk_tag[p*IDX_W +: IDX_W]),
            .ready    (lk_ready[p]),
            .value    (lk_value[p*DATA_W +: DATA_W])
        );
    end

    AST_ONE_RETIRE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_en, exc_raise})); // R4

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && disp_valid && !flush_valid && !exc_raise) |=> (disp_tag == $past(disp_tag))); // R2

    AST_EXC_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |=> (!rf_we && !st_en && !exc_raise && !full)); // R10

    AST_FLUSH_BLOCKS_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && !exc_raise) |=> (disp_tag == $past(flush_tag) + IDX_W'(1))); // R8
endmodule

// File: tb/tb_rob_top.sv
`timescale 1ns/1ps
module tb_rob_top;
    localparam int DEPTH  = 4;
    localparam int DATA_W = 8;
    localparam int DEST_W = 8;
    localparam int REG_W  = 5;
    localparam int NUM_RD = 2;
    localparam int IDX_W  = 2;
    localparam int NVEC   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [1:0] disp_kind = 2'd0;
    logic [DEST_W-1:0] disp_dest = '0;
    logic [IDX_W-1:0] disp_tag;
    logic full;
    logic res_valid = 1'b0;
    logic [IDX_W-1:0] res_tag = '0;
    logic [DATA_W-1:0] res_value = '0;
    logic res_exc = 1'b0;
    logic flush_valid = 1'b0;
    logic [IDX_W-1:0] flush_tag = '0;
    logic [NUM_RD*REG_W-1:0] lk_reg = '0;
    logic [NUM_RD-1:0] lk_busy;
    logic [NUM_RD*IDX_W-1:0] lk_tag;
    logic [NUM_RD-1:0] lk_ready;
    logic [NUM_RD*DATA_W-1:0] lk_value;
    logic rf_we;
    logic [REG_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_data;
    logic st_en;
    logic [DEST_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic exc_raise;
    logic [IDX_W-1:0] exc_tag;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    rob_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W),
              .NUM_RD(NUM_RD)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_kind(disp_kind), .disp_dest(disp_dest),
        .disp_tag(disp_tag), .full(full),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value), .res_exc(res_exc),
        .flush_valid(flush_valid), .flush_tag(flush_tag),
        .lk_reg(lk_reg), .lk_busy(lk_busy), .lk_tag(lk_tag), .lk_ready(lk_ready),
        .lk_value(lk_value),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
        .exc_raise(exc_raise), .exc_tag(exc_tag)
    );

    // One vector per cycle: inputs applied, expected outputs checked before them.
    typedef struct packed {
        logic       dv;
        logic [1:0] dk;
        logic [7:0] dd;
        logic       rv;
        logic [1:0] rt;
        logic [7:0] rval;
        logic       rexc;
        logic       e_we;
        logic       e_st;
        logic       e_exc;
        logic [7:0] e_addr;
        logic [7:0] e_data;
        logic       e_full;
        logic [1:0] e_dtag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // dv  dk    dd     rv  rt    rval   rexc we st exc addr   data   full dtag
        '{1'b1,2'd0,8'h03, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,2'd0},
        '{1'b1,2'd0,8'h05, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,2'd1},
        '{1'b1,2'd1,8'h40, 1'b1,2'd1,8'h11, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,2'd2},
        '{1'b1,2'd2,8'h00, 1'b1,2'd0,8'hA0, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,2'd3},
        '{1'b1,2'd0,8'h07, 1'b1,2'd2,8'h22, 1'b0,1'b1,1'b0,1'b0,8'h03,8'hA0,1'b1,2'd0},
        '{1'b0,2'd0,8'h00, 1'b1,2'd3,8'h00, 1'b0,1'b1,1'b0,1'b0,8'h05,8'h11,1'b0,2'd0},
        '{1'b1,2'd0,8'h09, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b1,1'b0,8'h40,8'h22,1'b0,2'd0},
        '{1'b1,2'd0,8'h09, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,2'd1},
        '{1'b0,2'd0,8'h00, 1'b1,2'd0,8'h90, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,2'd2},
        '{1'b0,2'd0,8'h00, 1'b1,2'd1,8'h91, 1'b1,1'b1,1'b0,1'b0,8'h09,8'h90,1'b0,2'd2},
        '{1'b0,2'd0,8'h00, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b0,1'b1,8'h00,8'h00,1'b0,2'd2},
        '{1'b0,2'd0,8'h00, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,2'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic disp_one(input logic [1:0] k, input logic [7:0] d);
        disp_valid = 1'b1;
        disp_kind  = k;
        disp_dest  = d;
        tick();
        disp_valid = 1'b0;
    endtask

    task automatic res_one(input logic [1:0] t, input logic [7:0] v, input logic x);
        res_valid = 1'b1;
        res_tag   = t;
        res_value = v;
        res_exc   = x;
        tick();
        res_valid = 1'b0;
        res_exc   = 1'b0;
    endtask

    task automatic chk_lk(input string req, input int p, input logic [4:0] r,
                          input logic busy, input logic [1:0] tag,
                          input logic rdy, input logic [7:0] val);
        lk_reg[p*REG_W +: REG_W] = r;
        #1;
        chk(req, 32'(lk_busy[p]), 32'(busy));
        if (busy) begin
            chk(req, 32'(lk_tag[p*IDX_W +: IDX_W]), 32'(tag));
            chk(req, 32'(lk_ready[p]), 32'(rdy));
            if (rdy) chk(req, 32'(lk_value[p*DATA_W +: DATA_W]), 32'(val));
        end
    endtask

    task automatic chk_retire(input string req, input logic we, input logic st,
                              input logic ex);
        chk(req, 32'(rf_we), 32'(we));
        chk(req, 32'(st_en), 32'(st));
        chk(req, 32'(exc_raise), 32'(ex));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        do_reset();
        // R12 reset state
        chk_retire("R12", 1'b0, 1'b0, 1'b0);
        chk("R12", 32'(full), 32'd0);
        chk("R12", 32'(disp_tag), 32'd0);

        // Vector walk: R1 R2 R3 R4 R5 R6 R10
        for (int i = 0; i < NVEC; i++) begin
            chk("R4", 32'(rf_we), 32'(VECS[i].e_we));
            chk("R6", 32'(st_en), 32'(VECS[i].e_st));
            chk("R10", 32'(exc_raise), 32'(VECS[i].e_exc));
            chk("R2", 32'(full), 32'(VECS[i].e_full));
            chk("R1", 32'(disp_tag), 32'(VECS[i].e_dtag));
            if (VECS[i].e_we) begin
                chk("R5", 32'(rf_addr), 32'(VECS[i].e_addr[4:0]));
                chk("R5", 32'(rf_data), 32'(VECS[i].e_data));
            end
            if (VECS[i].e_st) begin
                chk("R6", 32'(st_addr), 32'(VECS[i].e_addr));
                chk("R6", 32'(st_data), 32'(VECS[i].e_data));
            end
            disp_valid = VECS[i].dv;
            disp_kind  = VECS[i].dk;
            disp_dest  = VECS[i].dd;
            res_valid  = VECS[i].rv;
            res_tag    = VECS[i].rt;
            res_value  = VECS[i].rval;
            res_exc    = VECS[i].rexc;
            tick();
        end
        disp_valid = 1'b0;
        res_valid  = 1'b0;
        res_exc    = 1'b0;

        // R7 lookup: youngest producer wins, idle register not busy
        do_reset();
        disp_one(2'd0, 8'h04);
        disp_one(2'd0, 8'h04);
        disp_one(2'd0, 8'h06);
        chk_lk("R7", 0, 5'd4, 1'b1, 2'd1, 1'b0, 8'h00);
        chk_lk("R7", 1, 5'd10, 1'b0, 2'd0, 1'b0, 8'h00);
        res_one(2'd1, 8'h44, 1'b0);
        chk_lk("R7", 0, 5'd4, 1'b1, 2'd1, 1'b1, 8'h44);
        chk_lk("R7", 1, 5'd6, 1'b1, 2'd2, 1'b0, 8'h00);
        chk_retire("R4", 1'b0, 1'b0, 1'b0);

        // R8 / R9 mispredict
        do_reset();
        disp_one(2'd0, 8'h01);
        disp_one(2'd2, 8'h00);
        disp_one(2'd0, 8'h02);
        disp_one(2'd1, 8'h30);
        chk("R2", 32'(full), 32'd1);
        res_one(2'd2, 8'h77, 1'b0);
        flush_valid = 1'b1;
        flush_tag   = 2'd1;
        disp_valid  = 1'b1;
        disp_kind   = 2'd0;
        disp_dest   = 8'h0C;
        tick();
        flush_valid = 1'b0;
        disp_valid  = 1'b0;
        chk("R8", 32'(full), 32'd0);
        chk("R8", 32'(disp_tag), 32'd2);
        chk_lk("R8", 0, 5'd2, 1'b0, 2'd0, 1'b0, 8'h00);
        chk_lk("R8", 1, 5'd12, 1'b0, 2'd0, 1'b0, 8'h00);
        chk_lk("R8", 0, 5'd1, 1'b1, 2'd0, 1'b0, 8'h00);
        disp_one(2'd0, 8'h02);
        chk_lk("R9", 0, 5'd2, 1'b1, 2'd2, 1'b0, 8'h00);
        res_one(2'd0, 8'h10, 1'b0);
        chk_retire("R5", 1'b1, 1'b0, 1'b0);
        chk("R5", 32'(rf_addr), 32'd1);
        chk("R5", 32'(rf_data), 32'h10);
        res_one(2'd1, 8'h00, 1'b0);
        chk_retire("R6", 1'b0, 1'b0, 1'b0);
        tick();
        chk_retire("R9", 1'b0, 1'b0, 1'b0);
        res_one(2'd2, 8'h22, 1'b0);
        chk_retire("R9", 1'b1, 1'b0, 1'b0);
        chk("R9", 32'(rf_data), 32'h22);
        tick();
        chk("R8", 32'(disp_tag), 32'd3);

        // R11 fault on a squashed path is never raised
        do_reset();
        disp_one(2'd0, 8'h01);
        disp_one(2'd2, 8'h00);
        disp_one(2'd0, 8'h03);
        res_one(2'd2, 8'h33, 1'b1);
        flush_valid = 1'b1;
        flush_tag   = 2'd1;
        tick();
        flush_valid = 1'b0;
        res_one(2'd0, 8'h01, 1'b0);
        chk_retire("R11", 1'b1, 1'b0, 1'b0);
        res_one(2'd1, 8'h00, 1'b0);
        chk_retire("R11", 1'b0, 1'b0, 1'b0);
        tick();
        chk_retire("R11", 1'b0, 1'b0, 1'b0);
        chk("R11", 32'(disp_tag), 32'd2);

        // R10 precise fault at the head empties the buffer
        disp_one(2'd0, 8'h05);
        disp_one(2'd0, 8'h06);
        res_one(2'd3, 8'h60, 1'b0);
        res_one(2'd2, 8'h55, 1'b1);
        chk_retire("R10", 1'b0, 1'b0, 1'b1);
        chk("R10", 32'(exc_tag), 32'd2);
        tick();
        chk_retire("R10", 1'b0, 1'b0, 1'b0);
        chk_lk("R10", 0, 5'd6, 1'b0, 2'd0, 1'b0, 8'h00);
        chk("R10", 32'(disp_tag), 32'd3);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule